// File: doc/BRIEF.md
# Command Status and Interrupt Controller

This block keeps the status byte that a command-driven peripheral returns as the first byte of every response. The byte tells the host two things. Clear-to-send (CTS) says whether a new command may be sent. Seek/tune-complete (STC) is a sticky flag that reports the end of a background seek or tune. An error flag is set when the host sends a command while CTS is low. The block takes three inputs from the rest of the chip:
- an accepted-command strobe carrying a class and two argument bits;
- done and started indications from the execution engine;
- a completion event from the seek engine.

It drives an active-low interrupt pulse and a one-cycle cancel request to the seek engine.

Ordinary and query commands hold CTS low until the execution engine reports done. A seek/tune command holds CTS low only until the seek engine reports that the operation has started. The operation then runs on, and its completion later sets STC. STC stays set until one of two things happens: a status-query command arrives with its acknowledge bit set, or a new seek/tune command is accepted. A status query with its cancel bit set aborts a seek in flight. The seek engine is then expected to report completion, which sets STC as usual.

Top module: `cmd_status_ctrl`

## Requirements
- R1: After reset, `status_o` is 8'h80 (CTS=1, ERR=0, STC=0), `irq_no` is high and `cancel_o` is low. The byte layout is bit 7 = CTS, bit 6 = ERR, bit 0 = STC, and bits 5..1 are zero.
- R2: A command is accepted when `cmd_valid_i` is high while CTS is 1. CTS reads 0 from the cycle after acceptance. The class encoding is 2'b00 plain, 2'b01 seek/tune, 2'b10 status query, and 2'b11 behaves as plain.
- R3: After a plain or query command, CTS returns to 1 in the cycle after `exec_done_i`. `seek_started_i` has no effect on such a command, and `exec_done_i` has no effect when no command is outstanding.
- R4: After a seek/tune command, CTS returns to 1 in the cycle after `seek_started_i`, and `exec_done_i` has no effect on it.
- R5: STC reads 1 in the cycle after `seek_done_i` while a seek is in flight. `seek_done_i` with no seek in flight has no effect.
- R6: STC is cleared by an accepted status query with `cmd_ack_i`=1 and by an accepted seek/tune command. If `seek_done_i` coincides with an acknowledging query, the completion wins and STC reads 1. If it coincides with a new seek, the new seek wins and STC reads 0.
- R7: An accepted status query with `cmd_cancel_i`=1 while a seek is in flight raises `cancel_o` for exactly one cycle, starting the cycle after acceptance. With no seek in flight it does not raise `cancel_o`. The seek stays in flight until `seek_done_i`, which then sets STC.
- R8: A command presented while CTS is 0 sets ERR and is otherwise ignored: STC and `cancel_o` are unaffected. ERR clears when a command is next accepted.
- R9: When CTS rises and `cts_ien_i` is high at that edge, `irq_no` goes low from the same cycle in which CTS reads 1, for PULSE_LEN cycles. The same holds for STC with `stc_ien_i`. With the enable low, no pulse is produced.
- R10: A new interrupt request during an active pulse restarts the count, so the pulse ends PULSE_LEN cycles after the latest request. CTS and STC rising in the same cycle produce a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_class_i | input | 2 | Command class (00 plain, 01 seek/tune, 10 status query, 11 plain) |
| cmd_ack_i | input | 1 | Status-query acknowledge bit (clears STC) |
| cmd_cancel_i | input | 1 | Status-query cancel bit |
| exec_done_i | input | 1 | Execution engine finished the outstanding plain/query command |
| seek_started_i | input | 1 | Seek engine has started the outstanding seek/tune |
| seek_done_i | input | 1 | Seek engine has completed or aborted the operation |
| cts_ien_i | input | 1 | Interrupt enable for CTS rising |
| stc_ien_i | input | 1 | Interrupt enable for STC rising |
| status_o | output | 8 | Status byte returned as the first byte of a response |
| irq_no | output | 1 | Active-low interrupt pulse |
| cancel_o | output | 1 | One-cycle abort request to the seek engine |

## Verification
Two pairs of events can land in the same cycle. The first pair is seek completion and a STC clear: the completion can coincide with an acknowledging query, or with a new seek. The bench raises `seek_done_i` on the same edge as the command strobe and checks that STC ends set in the first case and clear in the second. The second pair is the two interrupt causes: CTS and STC can rise together, or a second cause can arrive while a pulse is still running. The bench counts the low cycles of `irq_no` and expects one unbroken pulse of PULSE_LEN cycles, or PULSE_LEN cycles counted from the later request.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;
  typedef enum logic [1:0] {
    CMD_PLAIN = 2'b00,
    CMD_SEEK  = 2'b01,
    CMD_QUERY = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_class_e;

  typedef enum logic [1:0] {
    WAIT_NONE  = 2'b00,
    WAIT_EXEC  = 2'b01,
    WAIT_START = 2'b10
  } wait_e;

  localparam int unsigned STAT_W  = 8;
  localparam int unsigned CTS_BIT = 7;
  localparam int unsigned ERR_BIT = 6;
  localparam int unsigned STC_BIT = 0;
endpackage

// File: rtl/csc_cts_track.sv
`timescale 1ns/1ps
module csc_cts_track
  import csc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  cmd_class_e cmd_class_i,
  input  logic       exec_done_i,
  input  logic       seek_started_i,
  output logic       accept_o,
  output logic       cts_o,
  output logic       err_o,
  output logic       cts_rise_o
);
  logic  cts_q, cts_d, err_q, err_d;
  wait_e wait_q, wait_d;

  assign accept_o = cmd_valid_i & cts_q;

  always_comb begin
    cts_d  = cts_q;
    err_d  = err_q;
    wait_d = wait_q;
    // completion of the outstanding command
    unique case (wait_q)
      WAIT_EXEC:  if (exec_done_i)    begin cts_d = 1'b1; wait_d = WAIT_NONE; end
      WAIT_START: if (seek_started_i) begin cts_d = 1'b1; wait_d = WAIT_NONE; end
      default: ;
    endcase
    if (cmd_valid_i) begin
      if (cts_q) begin
        cts_d  = 1'b0;
        err_d  = 1'b0;
        wait_d = (cmd_class_i == CMD_SEEK) ? WAIT_START : WAIT_EXEC;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cts_q  <= 1'b1;
      err_q  <= 1'b0;
      wait_q <= WAIT_NONE;
    end else begin
      cts_q  <= cts_d;
      err_q  <= err_d;
      wait_q <= wait_d;
    end
  end

  assign cts_o      = cts_q;
  assign err_o      = err_q;
  assign cts_rise_o = cts_d & ~cts_q;
endmodule

// File: rtl/csc_stc_track.sv
`timescale 1ns/1ps
module csc_stc_track
  import csc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  cmd_class_e cmd_class_i,
  input  logic       cmd_ack_i,
  input  logic       cmd_cancel_i,
  input  logic       seek_done_i,
  output logic       stc_o,
  output logic       stc_rise_o,
  output logic       cancel_o
);
  logic stc_q, stc_d, busy_q, busy_d, cancel_q, cancel_d;
  logic seek_acc, query_acc, done_ev;

  assign seek_acc  = accept_i & (cmd_class_i == CMD_SEEK);
  assign query_acc = accept_i & (cmd_class_i == CMD_QUERY);
  assign done_ev   = seek_done_i & busy_q;

  // priority: new seek > completion > acknowledge
  always_comb begin
    stc_d  = stc_q;
    busy_d = busy_q;
    if (seek_acc) begin
      stc_d  = 1'b0;
      busy_d = 1'b1;
    end else if (done_ev) begin
      stc_d  = 1'b1;
      busy_d = 1'b0;
    end else if (query_acc && cmd_ack_i) begin
      stc_d  = 1'b0;
    end
    cancel_d = query_acc & cmd_cancel_i & busy_q & ~done_ev;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stc_q    <= 1'b0;
      busy_q   <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      stc_q    <= stc_d;
      busy_q   <= busy_d;
      cancel_q <= cancel_d;
    end
  end

  assign stc_o      = stc_q;
  assign stc_rise_o = stc_d & ~stc_q;
  assign cancel_o   = cancel_q;
endmodule

// File: rtl/csc_irq_pulse.sv
`timescale 1ns/1ps
module csc_irq_pulse #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic irq_no
);
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;

  // retrigger: any request reloads the full length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (req_i)           cnt_q <= CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign irq_no = (cnt_q == '0);
endmodule

// File: rtl/cmd_status_ctrl.sv
`timescale 1ns/1ps
module cmd_status_ctrl
  import csc_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_class_i,
  input  logic       cmd_ack_i,
  input  logic       cmd_cancel_i,
  input  logic       exec_done_i,
  input  logic       seek_started_i,
  input  logic       seek_done_i,
  input  logic       cts_ien_i,
  input  logic       stc_ien_i,
  output logic [7:0] status_o,
  output logic       irq_no,
  output logic       cancel_o
);
  cmd_class_e cls;
  logic accept, cts, err, cts_rise, stc, stc_rise, irq_req;

  assign cls = cmd_class_e'(cmd_class_i);

  csc_cts_track u_cts (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_class_i    (cls),
    .exec_done_i    (exec_done_i),
    .seek_started_i (seek_started_i),
    .accept_o       (accept),
    .cts_o          (cts),
    .err_o          (err),
    .cts_rise_o     (cts_rise)
  );

  csc_stc_track u_stc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .cmd_class_i  (cls),
    .cmd_ack_i    (cmd_ack_i),
    .cmd_cancel_i (cmd_cancel_i),
    .seek_done_i  (seek_done_i),
    .stc_o        (stc),
    .stc_rise_o   (stc_rise),
    .cancel_o     (cancel_o)
  );

  assign irq_req = (cts_rise & cts_ien_i) | (stc_rise & stc_ien_i);

  csc_irq_pulse #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (irq_req),
    .irq_no (irq_no)
  );

  always_comb begin
    status_o          = '0;
    status_o[CTS_BIT] = cts;
    status_o[ERR_BIT] = err;
    status_o[STC_BIT] = stc;
  end
endmodule

// File: rtl/cmd_status_ctrl_chk.sv
`timescale 1ns/1ps
module cmd_status_ctrl_chk
  import csc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [1:0] cmd_class_i,
  input logic       cmd_ack_i,
  input logic       cmd_cancel_i,
  input logic       exec_done_i,
  input logic       seek_started_i,
  input logic       seek_done_i,
  input logic       cts_ien_i,
  input logic       stc_ien_i,
  input logic [7:0] status_o,
  input logic       irq_no,
  input logic       cancel_o
);
  logic cts, stc, err;
  assign cts = status_o[CTS_BIT];
  assign stc = status_o[STC_BIT];
  assign err = status_o[ERR_BIT];

  assert_cts_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cts |=> !cts);

  assert_cts_rise_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cts) |-> $past(exec_done_i || seek_started_i));

  assert_stc_rise_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stc) |-> $past(seek_done_i));

  assert_stc_clear_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stc) |-> $past(cmd_valid_i && cts &&
      (cmd_class_i == CMD_SEEK || (cmd_class_i == CMD_QUERY && cmd_ack_i))));

  assert_cancel_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> $past(cmd_valid_i && cts && cmd_class_i == CMD_QUERY && cmd_cancel_i));

  assert_reject_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !cts |=> err);

  assert_irq_cts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cts) && $past(cts_ien_i) |-> !irq_no);

  assert_irq_stc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stc) && $past(stc_ien_i) |-> !irq_no);
endmodule

bind cmd_status_ctrl cmd_status_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_class_i    (cmd_class_i),
  .cmd_ack_i      (cmd_ack_i),
  .cmd_cancel_i   (cmd_cancel_i),
  .exec_done_i    (exec_done_i),
  .seek_started_i (seek_started_i),
  .seek_done_i    (seek_done_i),
  .cts_ien_i      (cts_ien_i),
  .stc_ien_i      (stc_ien_i),
  .status_o       (status_o),
  .irq_no         (irq_no),
  .cancel_o       (cancel_o)
);

// File: tb/cmd_status_ctrl_tb.sv
`timescale 1ns/1ps
module cmd_status_ctrl_tb;
  localparam int PL = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_class = 2'b00;
  logic       cmd_ack = 1'b0, cmd_cancel = 1'b0;
  logic       exec_done = 1'b0, seek_started = 1'b0, seek_done = 1'b0;
  logic       cts_ien = 1'b0, stc_ien = 1'b0;
  logic [7:0] status;
  logic       irq_n, cancel;

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cmd_status_ctrl #(.PULSE_LEN(PL)) u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .cmd_valid_i    (cmd_valid),
    .cmd_class_i    (cmd_class),
    .cmd_ack_i      (cmd_ack),
    .cmd_cancel_i   (cmd_cancel),
    .exec_done_i    (exec_done),
    .seek_started_i (seek_started),
    .seek_done_i    (seek_done),
    .cts_ien_i      (cts_ien),
    .stc_ien_i      (stc_ien),
    .status_o       (status),
    .irq_no         (irq_n),
    .cancel_o       (cancel)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic issue(input logic [1:0] cls, input logic ack, input logic cnl);
    cmd_valid = 1'b1; cmd_class = cls; cmd_ack = ack; cmd_cancel = cnl;
    tick();
    cmd_valid = 1'b0; cmd_ack = 1'b0; cmd_cancel = 1'b0;
  endtask

  task automatic p_exec();  exec_done = 1'b1;    tick(); exec_done = 1'b0;    endtask
  task automatic p_start(); seek_started = 1'b1; tick(); seek_started = 1'b0; endtask
  task automatic p_done();  seek_done = 1'b1;    tick(); seek_done = 1'b0;    endtask

  // counts low cycles of irq_n: current sample plus n further cycles
  task automatic irq_low(input int n, output int c);
    c = (irq_n === 1'b0) ? 1 : 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (irq_n === 1'b0) c++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int n, c1, c2;
    tick(); tick();
    chk("R1", "status in reset", status, 8'h80);
    rst_ni = 1'b1;
    tick();
    chk("R1", "status after reset", status, 8'h80);
    chk("R1", "irq idle", irq_n, 1);
    chk("R1", "cancel idle", cancel, 0);

    // plain and query classes, with and without the CTS interrupt
    for (int c = 0; c < 4; c++) begin
      if (c == 1) continue;
      for (int ien = 0; ien < 2; ien++) begin
        cts_ien = ien[0];
        issue(c[1:0], 1'b0, 1'b0);
        chk("R2", "CTS low after accept", status, 8'h00);
        p_start();
        chk("R3", "started ignored by plain", status, 8'h00);
        tick();
        chk("R3", "CTS held while busy", status, 8'h00);
        p_exec();
        chk("R3", "CTS back after done", status, 8'h80);
        irq_low(PL + 2, n);
        chk("R9", "CTS pulse length", n, ien * PL);
        p_exec();
        chk("R3", "stray done ignored", status, 8'h80);
        chk("R3", "stray done no irq", irq_n, 1);
        p_done();
        chk("R5", "stray seek done ignored", status, 8'h80);
      end
    end

    // seek/tune across all enable combinations
    for (int en = 0; en < 4; en++) begin
      cts_ien = en[0]; stc_ien = en[1];
      issue(2'b01, 1'b0, 1'b0);
      chk("R2", "CTS low after seek", status, 8'h00);
      p_exec();
      chk("R4", "exec done ignored by seek", status, 8'h00);
      p_start();
      chk("R4", "CTS back on start", status, 8'h80);
      irq_low(PL + 2, n);
      chk("R9", "CTS pulse on seek start", n, en[0] * PL);
      p_done();
      chk("R5", "STC set on completion", status, 8'h81);
      irq_low(PL + 2, n);
      chk("R9", "STC pulse", n, en[1] * PL);
      issue(2'b10, 1'b1, 1'b0);
      chk("R6", "ack clears STC", status, 8'h00);
      p_exec();
      chk("R3", "query done", status, 8'h80);
      irq_low(PL + 2, n);
      chk("R9", "CTS pulse on query", n, en[0] * PL);
    end
    cts_ien = 1'b0; stc_ien = 1'b0;

    // cancel in flight and idle
    issue(2'b01, 1'b0, 1'b0); p_start();
    issue(2'b10, 1'b0, 1'b1);
    chk("R7", "cancel raised", cancel, 1);
    chk("R7", "status during cancel", status, 8'h00);
    tick();
    chk("R7", "cancel one cycle", cancel, 0);
    p_done();
    chk("R7", "aborted seek sets STC", status, 8'h01);
    p_exec();
    chk("R7", "query completes", status, 8'h81);
    issue(2'b10, 1'b1, 1'b0); p_exec();
    chk("R6", "ack clear", status, 8'h80);
    issue(2'b10, 1'b0, 1'b1);
    chk("R7", "no cancel when idle", cancel, 0);
    p_exec();
    chk("R7", "idle cancel query done", status, 8'h80);

    // completion coincides with acknowledging query: completion wins
    issue(2'b01, 1'b0, 1'b0); p_start();
    seek_done = 1'b1;
    issue(2'b10, 1'b1, 1'b0);
    seek_done = 1'b0;
    chk("R6", "done beats ack", status, 8'h01);
    p_exec();
    chk("R6", "after coincident ack", status, 8'h81);
    issue(2'b10, 1'b1, 1'b0); p_exec();
    chk("R6", "later ack clears", status, 8'h80);

    // completion coincides with new seek: new seek wins
    issue(2'b01, 1'b0, 1'b0); p_start();
    seek_done = 1'b1;
    issue(2'b01, 1'b0, 1'b0);
    seek_done = 1'b0;
    chk("R6", "new seek beats done", status, 8'h00);
    p_start();
    chk("R6", "restarted seek running", status, 8'h80);
    p_done();
    chk("R5", "restarted seek completes", status, 8'h81);
    issue(2'b10, 1'b1, 1'b0); p_exec();
    chk("R6", "cleanup", status, 8'h80);

    // rejected commands
    issue(2'b01, 1'b0, 1'b0); p_start(); p_done();
    chk("R5", "STC before reject", status, 8'h81);
    issue(2'b00, 1'b0, 1'b0);
    chk("R2", "plain keeps STC", status, 8'h01);
    issue(2'b10, 1'b1, 1'b1);
    chk("R8", "reject sets ERR keeps STC", status, 8'h41);
    chk("R8", "reject no cancel", cancel, 0);
    tick();
    chk("R8", "reject has no late effect", status, 8'h41);
    p_exec();
    chk("R8", "ERR persists", status, 8'hC1);
    issue(2'b00, 1'b0, 1'b0);
    chk("R8", "ERR cleared on accept", status, 8'h01);
    p_exec();
    issue(2'b10, 1'b1, 1'b0); p_exec();
    chk("R8", "cleanup", status, 8'h80);

    // retrigger
    cts_ien = 1'b1; stc_ien = 1'b1;
    issue(2'b01, 1'b0, 1'b0); p_start();
    irq_low(PL + 2, n);
    p_done();
    c1 = (irq_n === 1'b0) ? 1 : 0;
    issue(2'b00, 1'b0, 1'b0);
    c2 = (irq_n === 1'b0) ? 1 : 0;
    p_exec();
    chk("R10", "status at retrigger", status, 8'h81);
    irq_low(PL + 4, n);
    chk("R10", "retriggered pulse length", c1 + c2 + n, PL + 2);
    issue(2'b10, 1'b1, 1'b0); p_exec();
    irq_low(PL + 2, n);

    // CTS and STC rise in the same cycle: one pulse
    issue(2'b01, 1'b0, 1'b0); p_start();
    irq_low(PL + 2, n);
    issue(2'b00, 1'b0, 1'b0);
    exec_done = 1'b1; seek_done = 1'b1;
    tick();
    exec_done = 1'b0; seek_done = 1'b0;
    chk("R10", "both flags set", status, 8'h81);
    irq_low(PL + 2, n);
    chk("R10", "coincident single pulse", n, PL);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule